// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Tracker

This block models, on the device side, how a four-bank single-data-rate SDRAM reacts to its clock-enable pin. At every clock edge it looks at two things: the clock-enable level registered at the previous edge and the level present now. It also looks at the command lines (chip select, row strobe, column strobe, write enable), a bank address and an all-bank select. From these it keeps the operating mode: idle, active, clock-suspend, power-down, self-refresh or a one-cycle auto-refresh. While a read is suspended it freezes the read word it drives. While it is suspended for any other reason it drops its input-accept enable. It keeps an internal refresh row counter, and it pulses an error flag when a refresh is asked for while the device is busy.

A command is taken only at an edge where clock-enable was high at the edge before. This one rule covers three cases. A command given in the cycle that enters suspend is still carried out. Commands given while suspended or in a low-power mode are dropped. The command given at the edge that leaves suspend is dropped as well. The memory array, timing windows, mode-register contents and burst sequencing are not part of this block.

Top module: `sdr_cke_tracker`

## Requirements
- R1: After reset, mode is 0 (idle), ref_row is 0, cmd_err is 0, dq_hold is 0, in_accept is 1 and dq_out is 0.
- R2: A command is decoded from {cs_n, ras_n, cas_n, we_n} as follows: 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh, 0111 NOP, and cs_n high for deselect. It takes effect only at an edge where cke was high at the preceding edge. In idle, a read or write has no effect.
- R3: In idle or active, activate opens bank ba and puts the block in mode 1 (active). Precharge closes bank ba, or every bank when ap is 1. When no bank is left open and cke is high, the mode returns to 0 (idle).
- R4: In active, an edge with cke low enters mode 2 (clock suspend), and the command at that edge is still carried out. The mode stays 2 while cke is low. The first edge with cke high returns the mode to 1, or to 0 if no bank is open, and the command at that exit edge is ignored.
- R5: dq_out takes rd_data at each edge, except while dq_hold is high. dq_hold is high in suspend when the last column command was a read, and dq_out then keeps its word until the edge after the exit edge.
- R6: In a suspend that follows a write, or follows no column command, dq_hold stays 0 and in_accept is 0. After exit, the open banks are unchanged.
- R7: In idle with cke high at both edges, refresh enters mode 5 (auto-refresh) for exactly one cycle and increments ref_row. The block then returns to mode 0 with no precharge command.
- R8: ref_row wraps from 2**ROW_W-1 to 0 (8192 refreshes at the default ROW_W of 13).
- R9: In idle, refresh at an edge where cke falls enters mode 4 (self-refresh) without changing ref_row. The first edge with cke high returns the mode to 0.
- R10: In idle, NOP or deselect at an edge where cke falls enters mode 3 (power-down). Commands are ignored there, and the first edge with cke high returns the mode to 0.
- R11: A refresh taken in mode 1 or mode 5 raises cmd_err for one cycle. The refresh is not performed, and active stays active.
- R12: in_accept is 1 only in mode 0 or 1 when cke was high at the last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable level at this edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | $clog2(NUM_BANKS) | Bank address for activate and precharge |
| ap | input | 1 | Precharge targets all banks when 1 |
| rd_data | input | DATA_W | Read word from the array |
| mode | output | 3 | Current mode code |
| dq_hold | output | 1 | Read output frozen by suspend |
| in_accept | output | 1 | Commands and write data are accepted |
| ref_row | output | ROW_W | Internal refresh row counter |
| dq_out | output | DATA_W | Read word driven out |
| cmd_err | output | 1 | Refresh requested while busy |

## Verification
The bench builds the block with ROW_W set to 4 and DATA_W set to 8, keeping four banks. The narrow counter makes the wrap of the refresh row take 16 refreshes instead of 8192, so the rollover is checked directly. The narrow data path keeps the held and the captured words easy to tell apart. Four banks allow overlapping activations, so the return to idle is checked only once the last open bank is closed.

// File: rtl/sdr_cke_pkg.sv
package sdr_cke_pkg;

    typedef enum logic [2:0] {
        MODE_IDLE    = 3'd0,
        MODE_ACTIVE  = 3'd1,
        MODE_SUSPEND = 3'd2,
        MODE_PDOWN   = 3'd3,
        MODE_SELFREF = 3'd4,
        MODE_AREF    = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2
    } kind_e;

    typedef enum logic [2:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_REF,
        CMD_OTHER
    } cmd_e;

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
    import sdr_cke_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                default: cmd = CMD_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/sdr_refresh_ctr.sv
module sdr_refresh_ctr #(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [ROW_W-1:0] row
);

    logic [ROW_W-1:0] row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (inc) row_d = row_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign row = row_q;

endmodule

// File: rtl/sdr_cke_tracker.sv
module sdr_cke_tracker
    import sdr_cke_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int DATA_W    = 16,
    localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic              ap,
    input  logic [DATA_W-1:0] rd_data,
    output logic [2:0]        mode,
    output logic              dq_hold,
    output logic              in_accept,
    output logic [ROW_W-1:0]  ref_row,
    output logic [DATA_W-1:0] dq_out,
    output logic              cmd_err
);

    typedef struct packed {
        mode_e                mode;
        kind_e                kind;
        logic [NUM_BANKS-1:0] open;
        logic                 cke;
        logic                 err;
        logic [DATA_W-1:0]    dq;
    } state_t;

    localparam state_t ST_RESET = '{
        mode: MODE_IDLE, kind: KIND_NONE, open: '0,
        cke: 1'b1, err: 1'b0, dq: '0
    };

    state_t st_d, st_q;
    cmd_e   cmd;
    logic   take;
    logic   hold;
    logic   ref_inc;

    sdr_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    sdr_refresh_ctr #(.ROW_W(ROW_W)) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ref_inc),
        .row   (ref_row)
    );

    always_comb begin
        st_d    = st_q;
        st_d.cke = cke;
        st_d.err = 1'b0;
        ref_inc = 1'b0;
        take    = st_q.cke;
        hold    = (st_q.mode == MODE_SUSPEND) && (st_q.kind == KIND_READ);
        if (!hold) st_d.dq = rd_data;

        unique case (st_q.mode)
            MODE_IDLE: begin
                if (take) begin
                    if (cmd == CMD_REF) begin
                        if (cke) begin
                            st_d.mode = MODE_AREF;
                            ref_inc   = 1'b1;
                        end else begin
                            st_d.mode = MODE_SELFREF;
                        end
                    end else if (cmd == CMD_ACT) begin
                        st_d.open[ba] = 1'b1;
                        st_d.kind     = KIND_NONE;
                        st_d.mode     = cke ? MODE_ACTIVE : MODE_SUSPEND;
                    end else if (!cke && (cmd == CMD_NOP || cmd == CMD_DESEL)) begin
                        st_d.mode = MODE_PDOWN;
                    end
                end
            end
            MODE_ACTIVE: begin
                if (take) begin
                    unique case (cmd)
                        CMD_ACT: begin
                            st_d.open[ba] = 1'b1;
                            st_d.kind     = KIND_NONE;
                        end
                        CMD_PRE: begin
                            if (ap) st_d.open = '0;
                            else    st_d.open[ba] = 1'b0;
                            st_d.kind = KIND_NONE;
                        end
                        CMD_RD:  st_d.kind = KIND_READ;
                        CMD_WR:  st_d.kind = KIND_WRITE;
                        CMD_REF: st_d.err  = 1'b1;
                        default: ;
                    endcase
                end
                if (!cke) begin
                    st_d.mode = MODE_SUSPEND;
                end else if (st_d.open == '0) begin
                    st_d.mode = MODE_IDLE;
                    st_d.kind = KIND_NONE;
                end
            end
            MODE_SUSPEND: begin
                if (cke) begin
                    if (st_q.open != '0) begin
                        st_d.mode = MODE_ACTIVE;
                    end else begin
                        st_d.mode = MODE_IDLE;
                        st_d.kind = KIND_NONE;
                    end
                end
            end
            MODE_PDOWN, MODE_SELFREF: begin
                if (cke) st_d.mode = MODE_IDLE;
            end
            MODE_AREF: begin
                if (take && cmd == CMD_REF) st_d.err = 1'b1;
                st_d.open = '0;
                st_d.mode = MODE_IDLE;
            end
            default: st_d = ST_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign mode      = st_q.mode;
    assign dq_hold   = hold;
    assign in_accept = st_q.cke && (st_q.mode == MODE_IDLE || st_q.mode == MODE_ACTIVE);
    assign dq_out    = st_q.dq;
    assign cmd_err   = st_q.err;

endmodule

// File: rtl/sdr_cke_tracker_chk.sv
module sdr_cke_tracker_chk
    import sdr_cke_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic [2:0]        mode,
    input logic              dq_hold,
    input logic              in_accept,
    input logic [ROW_W-1:0]  ref_row,
    input logic [DATA_W-1:0] dq_out,
    input logic              cmd_err
);

    AST_REF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_AREF) |-> ref_row == ROW_W'($past(ref_row) + 1'b1)); // R7

    AST_ROW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_AREF) |-> $stable(ref_row)); // R9

    AST_AREF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_AREF) |=> (mode == MODE_IDLE)); // R7

    AST_DQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dq_hold) |-> $stable(dq_out)); // R5

    AST_ERR_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> ($past(mode) == MODE_ACTIVE || $past(mode) == MODE_AREF)); // R11

    AST_SUSPEND_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SUSPEND && !cke) |=> (mode == MODE_SUSPEND)); // R4

    AST_LOWPWR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_PDOWN || mode == MODE_SELFREF) && !$stable(mode))
        |-> ($past(mode) == MODE_IDLE)); // R10

    AST_LOWPWR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_PDOWN || mode == MODE_SELFREF) && cke) |=> (mode == MODE_IDLE)); // R9

    AST_ACCEPT_NEEDS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        in_accept |-> $past(cke)); // R12

endmodule

bind sdr_cke_tracker sdr_cke_tracker_chk #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .mode      (mode),
    .dq_hold   (dq_hold),
    .in_accept (in_accept),
    .ref_row   (ref_row),
    .dq_out    (dq_out),
    .cmd_err   (cmd_err)
);

// File: tb/tb_sdr_cke_tracker.sv
module tb_sdr_cke_tracker;

    localparam int ROW_W  = 4;
    localparam int DATA_W = 8;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_DES = 4'b1111;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;

    typedef struct packed {
        logic       cke;
        logic [3:0] cmd;
        logic [1:0] ba;
        logic       ap;
        logic [2:0] mode;
        logic       hold;
        logic       acc;
        logic       err;
        logic [3:0] row;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VECS [NV] = '{
        '{1'b1, C_NOP, 2'd0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd0, 4'd2},  // R2 idle NOP
        '{1'b1, C_REF, 2'd0, 1'b0, 3'd5, 1'b0, 1'b0, 1'b0, 4'd1, 4'd7},  // R7 auto-refresh
        '{1'b1, C_NOP, 2'd0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd1, 4'd7},  // R7 back to idle
        '{1'b1, C_ACT, 2'd2, 1'b0, 3'd1, 1'b0, 1'b1, 1'b0, 4'd1, 4'd3},  // R3 open bank 2
        '{1'b1, C_REF, 2'd0, 1'b0, 3'd1, 1'b0, 1'b1, 1'b1, 4'd1, 4'd11}, // R11 refresh while active
        '{1'b1, C_NOP, 2'd0, 1'b0, 3'd1, 1'b0, 1'b1, 1'b0, 4'd1, 4'd11}, // R11 one-cycle pulse
        '{1'b1, C_RD,  2'd2, 1'b0, 3'd1, 1'b0, 1'b1, 1'b0, 4'd1, 4'd5},  // R5 read
        '{1'b0, C_NOP, 2'd0, 1'b0, 3'd2, 1'b1, 1'b0, 1'b0, 4'd1, 4'd4},  // R4 enter read suspend
        '{1'b0, C_PRE, 2'd0, 1'b1, 3'd2, 1'b1, 1'b0, 1'b0, 4'd1, 4'd5},  // R5 held, PRE ignored
        '{1'b1, C_PRE, 2'd0, 1'b1, 3'd1, 1'b0, 1'b1, 1'b0, 4'd1, 4'd4},  // R4 exit, PRE ignored
        '{1'b1, C_NOP, 2'd0, 1'b0, 3'd1, 1'b0, 1'b1, 1'b0, 4'd1, 4'd4},  // R4 bank still open
        '{1'b1, C_WR,  2'd2, 1'b0, 3'd1, 1'b0, 1'b1, 1'b0, 4'd1, 4'd6},  // R6 write
        '{1'b0, C_NOP, 2'd0, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 4'd1, 4'd6},  // R6 write suspend
        '{1'b0, C_WR,  2'd0, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 4'd1, 4'd6},  // R6 inputs blocked
        '{1'b1, C_NOP, 2'd0, 1'b0, 3'd1, 1'b0, 1'b1, 1'b0, 4'd1, 4'd6},  // R6 exit keeps bank
        '{1'b1, C_PRE, 2'd2, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd1, 4'd3},  // R3 last bank closed
        '{1'b1, C_ACT, 2'd1, 1'b0, 3'd1, 1'b0, 1'b1, 1'b0, 4'd1, 4'd3},  // R3
        '{1'b1, C_ACT, 2'd3, 1'b0, 3'd1, 1'b0, 1'b1, 1'b0, 4'd1, 4'd3},  // R3 two banks
        '{1'b1, C_PRE, 2'd1, 1'b0, 3'd1, 1'b0, 1'b1, 1'b0, 4'd1, 4'd3},  // R3 one still open
        '{1'b0, C_PRE, 2'd0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 4'd1, 4'd4},  // R4 entry PRE executes
        '{1'b1, C_NOP, 2'd0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd1, 4'd4},  // R4 exit to idle
        '{1'b0, C_DES, 2'd0, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 4'd1, 4'd10}, // R10 power-down
        '{1'b0, C_REF, 2'd0, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 4'd1, 4'd10}, // R10 REF ignored
        '{1'b1, C_NOP, 2'd0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd1, 4'd10}, // R10 exit
        '{1'b0, C_REF, 2'd0, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 4'd1, 4'd9},  // R9 self-refresh
        '{1'b0, C_NOP, 2'd0, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 4'd1, 4'd9},  // R9 stays
        '{1'b1, C_NOP, 2'd0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd1, 4'd9},  // R9 exit, row kept
        '{1'b1, C_REF, 2'd0, 1'b0, 3'd5, 1'b0, 1'b0, 1'b0, 4'd2, 4'd7},  // R7
        '{1'b1, C_REF, 2'd0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 4'd2, 4'd11}, // R11 REF during refresh
        '{1'b1, C_NOP, 2'd0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd2, 4'd12}, // R12
        '{1'b1, C_WR,  2'd0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd2, 4'd2}   // R2 write in idle ignored
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cke = 1'b1;
    logic              cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]        ba = '0;
    logic              ap = 1'b0;
    logic [DATA_W-1:0] rd_data = '0;
    logic [2:0]        mode;
    logic              dq_hold, in_accept, cmd_err;
    logic [ROW_W-1:0]  ref_row;
    logic [DATA_W-1:0] dq_out;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sdr_cke_tracker #(.NUM_BANKS(4), .ROW_W(ROW_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .ap(ap), .rd_data(rd_data),
        .mode(mode), .dq_hold(dq_hold), .in_accept(in_accept),
        .ref_row(ref_row), .dq_out(dq_out), .cmd_err(cmd_err)
    );

    task automatic step(input logic k, input logic [3:0] c, input logic [1:0] b,
                        input logic a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        cke = k;
        {cs_n, ras_n, cas_n, we_n} = c;
        ba = b;
        ap = a;
        rd_data = d;
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input logic [2:0] em, input logic eh,
                         input logic ea, input logic ee, input logic [ROW_W-1:0] er,
                         input logic [DATA_W-1:0] ed);
        n_chk++;
        if (mode !== em || dq_hold !== eh || in_accept !== ea || cmd_err !== ee ||
            ref_row !== er || dq_out !== ed) begin
            n_bad++;
            $display("FAIL %s: got mode=%0d hold=%0b acc=%0b err=%0b row=%0d dq=%0h, expected mode=%0d hold=%0b acc=%0b err=%0b row=%0d dq=%0h",
                     tag, mode, dq_hold, in_accept, cmd_err, ref_row, dq_out,
                     em, eh, ea, ee, er, ed);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got no completion, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] exp_dq;
        logic              prev_hold;
        logic [ROW_W-1:0]  row;

        repeat (3) @(posedge clk);
        #2;
        check("R1 reset held", 3'd0, 1'b0, 1'b1, 1'b0, '0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check("R1 after release", 3'd0, 1'b0, 1'b1, 1'b0, '0, '0);

        exp_dq    = '0;
        prev_hold = 1'b0;
        for (int i = 0; i < NV; i++) begin
            logic [DATA_W-1:0] d;
            d = DATA_W'(8'h40 + i);
            step(VECS[i].cke, VECS[i].cmd, VECS[i].ba, VECS[i].ap, d);
            if (!prev_hold) exp_dq = d;
            check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].mode,
                  VECS[i].hold, VECS[i].acc, VECS[i].err, VECS[i].row, exp_dq);
            prev_hold = VECS[i].hold;
        end

        // R8: run the counter up to its top value, then wrap it to zero
        row = 4'd2;
        while (row != 4'd15) begin
            step(1'b1, C_REF, 2'd0, 1'b0, 8'h11);
            step(1'b1, C_NOP, 2'd0, 1'b0, 8'h22);
            row = row + 1'b1;
        end
        check("R8 at top", 3'd0, 1'b0, 1'b1, 1'b0, 4'd15, 8'h22);
        step(1'b1, C_REF, 2'd0, 1'b0, 8'h33);
        check("R8 wrap", 3'd5, 1'b0, 1'b0, 1'b0, 4'd0, 8'h33);
        step(1'b1, C_NOP, 2'd0, 1'b0, 8'h44);
        check("R7 idle after wrap", 3'd0, 1'b0, 1'b1, 1'b0, 4'd0, 8'h44);

        // R1: reset in the middle of a read suspend
        step(1'b1, C_REF, 2'd0, 1'b0, 8'h50);
        step(1'b1, C_NOP, 2'd0, 1'b0, 8'h51);
        step(1'b1, C_ACT, 2'd0, 1'b0, 8'h52);
        step(1'b1, C_RD,  2'd0, 1'b0, 8'h53);
        step(1'b0, C_NOP, 2'd0, 1'b0, 8'h54);
        check("R5 suspend before reset", 3'd2, 1'b1, 1'b0, 1'b0, 4'd1, 8'h54);
        @(negedge clk);
        rst_n = 1'b0;
        cke = 1'b1;
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
        #2;
        check("R1 mid-run reset", 3'd0, 1'b0, 1'b1, 1'b0, '0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, C_NOP, 2'd0, 1'b0, 8'h60);
        check("R12 after second reset", 3'd0, 1'b0, 1'b1, 1'b0, '0, 8'h60);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule